// File: doc/BRIEF.md
# Two-Channel DMA Bus Ownership Arbiter

This block decides who owns the system bus for each transfer unit: the CPU or one of two DMA channels. Every channel has its own request line and a mode bit that selects how it holds the bus. A cycle-steal channel gives the bus up after each unit. A burst channel keeps the bus for as long as it goes on requesting. A global select picks either fixed priority, in which channel 0 ranks above channel 1, or round-robin priority, in which the channel just served drops to the bottom.

The datapath pulses a done strobe when the unit in flight completes. The arbiter re-decides ownership only at that point. While the CPU owns the bus it re-decides on every cycle. The grant is a registered one-hot vector, so a decision made from the inputs of one cycle appears on the next cycle. Under fixed priority, cycle-steal and burst channels may run together and their units interleave. Under round-robin, that mix is illegal: the block raises an error flag and holds the bus for the CPU at every decision point.

Top module: `dmab_arbiter`

## Requirements
- R1: After reset, grant is 3'b001 (bit 0 CPU, bit 1 channel 0, bit 2 channel 1), cfg_err is 0, and the round-robin pointer favours channel 0.
- R2: grant always has exactly one bit set.
- R3: While a channel owns the bus and unit_done is low, grant does not change on the next cycle, whatever the requests do.
- R4: Under fixed priority (rr_mode = 0), when the CPU owns the bus and channel 0 requests, channel 0 receives the grant on the next cycle, even if channel 1 also requests.
- R5: When a cycle-steal channel (burst_sel bit = 0) signals unit_done, the grant moves on the next cycle to the other channel if that channel requests. Otherwise it moves to the CPU.
- R6: When a burst channel (burst_sel bit = 1) signals unit_done and still requests, it keeps the bus. The one exception is fixed priority with channel 1 as owner and channel 0 requesting: channel 0 then takes the bus.
- R7: When no channel requests, the bus returns to the CPU at the next decision point and stays there.
- R8: Under round-robin, each grant to channel k points the priority at the other channel. With both channels requesting at a decision point, the favoured channel wins.
- R9: Under round-robin, when a cycle-steal channel and a burst channel both request, cfg_err is 1 on the next cycle. Every decision point then hands the bus to the CPU, and no channel is granted.
- R10: Under fixed priority, a cycle-steal channel 0 and a burst channel 1 that both request alternate unit by unit, and cfg_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | NUM_CH | Per-channel transfer request |
| burst_sel | input | NUM_CH | Per-channel bus mode: 1 burst, 0 cycle steal |
| rr_mode | input | 1 | Priority select: 1 round-robin, 0 fixed |
| unit_done | input | 1 | Pulse from the datapath when the current unit completes |
| grant | output | NUM_CH+1 | One-hot owner: bit 0 CPU, bit k+1 channel k |
| cfg_err | output | 1 | Illegal mode mix under round-robin |

## Verification
Directed steps first run both channels in cycle-steal mode under fixed priority. This separates the fixed-order win from the hand-back after each unit. A lone burst channel then shows retention, and a cycle-steal channel 0 joining a burst channel 1 shows preemption and interleaving. The same requests under round-robin expose the pointer rotation. A round-robin burst/steal mix tells the error path apart from ordinary arbitration. Random requests, done pulses and mode changes then run against a behavioural model on every cycle, covering sequences the directed steps do not reach, such as requests dropping in the middle of a unit.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
    // Owner code 0 is always the CPU; channel k is owner k+1.
    localparam int unsigned DMAB_OWNER_CPU = 0;

    typedef enum logic {
        PRI_FIXED = 1'b0,
        PRI_ROTATE = 1'b1
    } dmab_pri_e;
endpackage

// File: rtl/dmab_mix_check.sv
module dmab_mix_check #(
    parameter int unsigned NUM_CH = 2
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] burst,
    input  logic              rotate,
    output logic              mix_err
);
    logic any_burst;
    logic any_steal;

    always_comb begin
        any_burst = |(req & burst);
        any_steal = |(req & ~burst);
        mix_err   = rotate & any_burst & any_steal;
    end
endmodule

// File: rtl/dmab_hold.sv
module dmab_hold #(
    parameter int unsigned NUM_CH = 2,
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              owner_is_ch,
    input  logic [IDX_W-1:0]  owner_ch,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] burst,
    input  logic              rotate,
    input  logic              done,
    output logic              keep_bus
);
    logic higher_req;
    logic own_burst;
    logic own_req;

    always_comb begin
        higher_req = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (i < int'(owner_ch) && req[i]) begin
                higher_req = 1'b1;
            end
        end
        own_burst = burst[owner_ch];
        own_req   = req[owner_ch];
        keep_bus  = owner_is_ch &
                    (~done | (own_burst & own_req & (rotate | ~higher_req)));
    end
endmodule

// File: rtl/dmab_pick.sv
module dmab_pick #(
    parameter int unsigned NUM_CH = 2,
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req,
    input  logic              excl_en,
    input  logic [IDX_W-1:0]  excl_idx,
    input  logic              rotate,
    input  logic [IDX_W-1:0]  ptr,
    output logic              found,
    output logic [IDX_W-1:0]  win
);
    int idx;

    always_comb begin
        found = 1'b0;
        win   = '0;
        idx   = 0;
        for (int off = 0; off < NUM_CH; off++) begin
            idx = rotate ? ((int'(ptr) + off) % NUM_CH) : off;
            if (!found && req[idx] && !(excl_en && idx == int'(excl_idx))) begin
                found = 1'b1;
                win   = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/dmab_arbiter.sv
module dmab_arbiter
    import dmab_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned OWN_W = $clog2(NUM_CH + 1),
    localparam int unsigned GNT_W = NUM_CH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] dma_req,
    input  logic [NUM_CH-1:0] burst_sel,
    input  logic              rr_mode,
    input  logic              unit_done,
    output logic [GNT_W-1:0]  grant,
    output logic              cfg_err
);
    typedef struct packed {
        logic [OWN_W-1:0] owner;
        logic [IDX_W-1:0] ptr;
        logic             cfg_err;
    } arb_state_t;

    arb_state_t st_d;
    arb_state_t st_q;

    dmab_pri_e        pri_mode;
    logic             owner_is_ch;
    logic [IDX_W-1:0] owner_ch;
    logic             mix_err;
    logic             keep_bus;
    logic             pick_found;
    logic [IDX_W-1:0] pick_win;

    always_comb begin
        pri_mode    = dmab_pri_e'(rr_mode);
        owner_is_ch = (st_q.owner != OWN_W'(DMAB_OWNER_CPU));
        owner_ch    = owner_is_ch ? IDX_W'(st_q.owner - OWN_W'(1)) : '0;
    end

    dmab_mix_check #(.NUM_CH(NUM_CH)) u_mix (
        .req     (dma_req),
        .burst   (burst_sel),
        .rotate  (pri_mode == PRI_ROTATE),
        .mix_err (mix_err)
    );

    dmab_hold #(.NUM_CH(NUM_CH)) u_hold (
        .owner_is_ch (owner_is_ch),
        .owner_ch    (owner_ch),
        .req         (dma_req),
        .burst       (burst_sel),
        .rotate      (pri_mode == PRI_ROTATE),
        .done        (unit_done),
        .keep_bus    (keep_bus)
    );

    dmab_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req      (dma_req),
        .excl_en  (owner_is_ch),
        .excl_idx (owner_ch),
        .rotate   (pri_mode == PRI_ROTATE),
        .ptr      (st_q.ptr),
        .found    (pick_found),
        .win      (pick_win)
    );

    always_comb begin
        st_d         = st_q;
        st_d.cfg_err = mix_err;
        if (!keep_bus) begin
            if (mix_err || !pick_found) begin
                st_d.owner = OWN_W'(DMAB_OWNER_CPU);
            end else begin
                st_d.owner = OWN_W'(pick_win) + OWN_W'(1);
                st_d.ptr   = (int'(pick_win) == NUM_CH - 1) ? '0
                                                             : IDX_W'(pick_win + IDX_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_W'(DMAB_OWNER_CPU), ptr: '0, cfg_err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < GNT_W; g++) begin : g_gnt
        assign grant[g] = (st_q.owner == OWN_W'(g));
    end

    assign cfg_err = st_q.cfg_err;
endmodule

// File: rtl/dmab_arbiter_chk.sv
module dmab_arbiter_chk #(
    parameter int unsigned NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] dma_req,
    input logic [NUM_CH-1:0] burst_sel,
    input logic              rr_mode,
    input logic              unit_done,
    input logic [NUM_CH:0]   grant,
    input logic              cfg_err
);
    logic mix_seen;
    assign mix_seen = rr_mode & (|(dma_req & burst_sel)) & (|(dma_req & ~burst_sel));

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) == 1);

    // R3
    mid_unit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant[0] && !unit_done) |=> $stable(grant));

    // R4
    fixed_ch0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && !rr_mode && dma_req[0]) |=> grant[1]);

    // R5
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[1] && !burst_sel[0] && unit_done && ((dma_req >> 1) == '0)) |=> grant[0]);

    // R7
    idle_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && dma_req == '0) |=> grant[0]);

    // R9
    mix_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mix_seen |=> cfg_err);

    // R9
    mix_no_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && mix_seen) |=> grant[0]);
endmodule

bind dmab_arbiter dmab_arbiter_chk #(.NUM_CH(NUM_CH)) u_arb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_req   (dma_req),
    .burst_sel (burst_sel),
    .rr_mode   (rr_mode),
    .unit_done (unit_done),
    .grant     (grant),
    .cfg_err   (cfg_err)
);

// File: tb/dmab_arbiter_bench.sv
module dmab_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] dma_req = '0;
    logic [1:0] burst_sel = '0;
    logic       rr_mode = 1'b0;
    logic       unit_done = 1'b0;
    logic [2:0] grant;
    logic       cfg_err;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // Behavioural model: owner 0 = CPU, 1 = channel 0, 2 = channel 1
    int m_own = 0;
    int m_ptr = 0;
    bit m_err = 0;

    dmab_arbiter u_dmab_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_req   (dma_req),
        .burst_sel (burst_sel),
        .rr_mode   (rr_mode),
        .unit_done (unit_done),
        .grant     (grant),
        .cfg_err   (cfg_err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_own = 0; m_ptr = 0; m_err = 0;
        end else begin
            bit mix;
            bit decide;
            int order [2];
            mix = rr_mode && dma_req[0] && dma_req[1] && (burst_sel[0] != burst_sel[1]);
            decide = 1;
            if (m_own != 0) begin
                int c;
                c = m_own - 1;
                if (!unit_done) decide = 0;
                else if (burst_sel[c] && dma_req[c] && !(!rr_mode && c == 1 && dma_req[0]))
                    decide = 0;
            end
            if (decide) begin
                if (mix) m_own = 0;
                else begin
                    int nxt;
                    nxt = 0;
                    order[0] = rr_mode ? m_ptr : 0;
                    order[1] = 1 - order[0];
                    foreach (order[i]) begin
                        if (nxt == 0 && dma_req[order[i]] && (m_own != order[i] + 1))
                            nxt = order[i] + 1;
                    end
                    m_own = nxt;
                    if (nxt != 0) m_ptr = (nxt == 1) ? 1 : 0;
                end
            end
            m_err = mix;
        end
    end

    task automatic chk_gnt(input logic [2:0] exp, input string tag);
        checks++;
        if (grant !== exp) begin
            fails++;
            $display("FAIL %s grant actual=%b expected=%b", tag, grant, exp);
        end
    endtask

    task automatic chk_err(input logic exp, input string tag);
        checks++;
        if (cfg_err !== exp) begin
            fails++;
            $display("FAIL %s cfg_err actual=%b expected=%b", tag, cfg_err, exp);
        end
    endtask

    // Drive at a falling edge, then wait one cycle so the result is visible.
    task automatic step(input logic [1:0] rq, input logic [1:0] bs,
                        input logic rr, input logic dn);
        dma_req = rq; burst_sel = bs; rr_mode = rr; unit_done = dn;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_gnt(3'b001, "R1"); chk_err(1'b0, "R1");

        step(2'b11, 2'b00, 0, 0); chk_gnt(3'b010, "R4");
        step(2'b11, 2'b00, 0, 0); chk_gnt(3'b010, "R3");
        step(2'b10, 2'b00, 0, 1); chk_gnt(3'b100, "R5");
        step(2'b00, 2'b00, 0, 1); chk_gnt(3'b001, "R7");
        step(2'b10, 2'b10, 0, 0); chk_gnt(3'b100, "R6");
        step(2'b10, 2'b10, 0, 1); chk_gnt(3'b100, "R6");
        step(2'b11, 2'b10, 0, 1); chk_gnt(3'b010, "R10"); chk_err(1'b0, "R10");
        step(2'b11, 2'b10, 0, 1); chk_gnt(3'b100, "R10");
        step(2'b00, 2'b10, 0, 1); chk_gnt(3'b001, "R7");
        step(2'b11, 2'b00, 1, 0); chk_gnt(3'b010, "R8");
        step(2'b11, 2'b00, 1, 1); chk_gnt(3'b100, "R8");
        step(2'b11, 2'b00, 1, 1); chk_gnt(3'b010, "R8");
        step(2'b11, 2'b11, 1, 1); chk_gnt(3'b010, "R6");
        step(2'b00, 2'b11, 1, 1); chk_gnt(3'b001, "R7");
        step(2'b11, 2'b01, 1, 0); chk_gnt(3'b001, "R9"); chk_err(1'b1, "R9");
        step(2'b11, 2'b01, 1, 1); chk_gnt(3'b001, "R9"); chk_err(1'b1, "R9");
        step(2'b00, 2'b01, 1, 0); chk_gnt(3'b001, "R9"); chk_err(1'b0, "R9");

        for (int n = 0; n < 4000; n++) begin
            logic [1:0] rq;
            logic [1:0] bs;
            logic       rr;
            rq = 2'($urandom_range(0, 3));
            bs = (n % 97 == 0) ? 2'($urandom_range(0, 3)) : burst_sel;
            rr = (n % 211 == 0) ? 1'($urandom_range(0, 1)) : rr_mode;
            step(rq, bs, rr, 1'($urandom_range(0, 2) == 0));
            checks++;
            if ($countones(grant) != 1) begin
                fails++;
                $display("FAIL R2 grant actual=%b expected=one-hot", grant);
            end
            chk_gnt(3'b001 << m_own, "R3 R5 R6 R8 model");
            chk_err(m_err, "R9 model");
        end
        finish_run();
    end
endmodule